// File: doc/BRIEF.md
# H-Bridge Winding Current Chopper Controller

This block is the digital control core for one winding of a bipolar stepper motor driven by a full H-bridge. It decides, on every clock, which of the four bridge switches are on. A direction bit picks one of the two diagonal switch pairs. A 3-bit current-level code is registered and passed to an external reference DAC. A current-trip flag from an external sense comparator ends the conduction phase of each chopping cycle.

When a trip is accepted, the bridge enters a fixed off-time. What happens during the off-time depends on a 2-bit decay select. In slow decay the low-side switch stays on so the current recirculates. In fast decay every switch is off. In mixed decay the first part of the off-time is fast and the rest is slow. When the off-time ends, the diagonal pair conducts again.

The trip flag is synchronized and then blanked for a short window after each turn-on, so switching transients do not cause false trips. Each direction change, and each exit from a zero current code, holds the bridge fully off for a dead time. A zero code forces every switch off. All timing is set by parameters given in clock cycles.

Top module: `hbridge_pwm_ctrl`

## Requirements
- R1: With `dir_i`=0 the conducting pair is `hs_a_o`+`ls_b_o`; with `dir_i`=1 it is `hs_b_o`+`ls_a_o`. The other pair's outputs stay 0.
- R2: Each chopping cycle begins with the high-side and the low-side switch of the selected pair both on.
- R3: A trip seen at `trip_i` for more than SYNC_STAGES cycles outside the blanking window ends the on phase one cycle after the synchronizer output rises.
- R4: With `decay_i`=2'b00 (slow) latched at the trip, only the low-side switch of the active pair is on for the whole off-time.
- R5: With `decay_i`=2'b01 or 2'b11 (fast) latched at the trip, all four outputs are 0 for the whole off-time.
- R6: With `decay_i`=2'b10 (mixed), all outputs are 0 for the first OFF_CYCLES*MIX_FAST_NUM/MIX_FAST_DEN off cycles (10 by default). The low-side switch of the active pair is then on for the rest of the off-time.
- R7: The off-time lasts exactly OFF_CYCLES cycles (40 by default). After it, the selected pair conducts again.
- R8: A change of `dir_i` holds all four outputs at 0 for exactly DEAD_CYCLES cycles (50 by default) before the new pair conducts. One pair never hands over to the other without an all-off cycle in between.
- R9: While `dac_code_o` is 0, all four outputs are 0, whatever the direction, decay or trip state. `dac_code_o` takes the value of `level_i` one clock after it is sampled. Leaving code 0 costs DEAD_CYCLES all-off cycles before conduction.
- R10: The trip is ignored during the first BLANK_CYCLES cycles of every on phase (8 by default), so a trip held high gives on phases of exactly BLANK_CYCLES+1 cycles. A trip during the off-time has no effect on its length.
- R11: The high-side and low-side outputs of the same leg are never 1 together.
- R12: Reset (`rst_n` low) drives all outputs and `dac_code_o` to 0. After release with a nonzero code, the bridge stays off for DEAD_CYCLES cycles before the first conduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Winding current direction |
| level_i | input | LEVEL_W | Current-level code; 0 turns the bridge off |
| decay_i | input | 2 | Decay select: 00 slow, 01/11 fast, 10 mixed |
| trip_i | input | 1 | Current-trip flag from the sense comparator |
| hs_a_o | output | 1 | High-side switch enable, leg A |
| ls_a_o | output | 1 | Low-side switch enable, leg A |
| hs_b_o | output | 1 | High-side switch enable, leg B |
| ls_b_o | output | 1 | Low-side switch enable, leg B |
| dac_code_o | output | LEVEL_W | Registered level code for the reference DAC |

## Verification
The hardest condition to reach is a trip arriving exactly while the blanking window is still open. From outside, the start of an on phase can only be seen one cycle late, and the synchronizer adds its own delay. To get there, the stimulus raises the trip during an off-time, where it is ignored, and keeps it high. The synchronized flag is therefore already settled when the next on phase starts. The bench then measures the on-phase length and expects BLANK_CYCLES+1, and it also checks that the off-time was not shortened. The mixed-decay split point is reached in a similar way: the bench counts the all-off cycles after a trip before the low-side switch returns.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic [1:0] {
        PH_DEAD = 2'b00,
        PH_ON   = 2'b01,
        PH_OFF  = 2'b10
    } phase_e;

    typedef enum logic [1:0] {
        DK_SLOW  = 2'b00,
        DK_FAST  = 2'b01,
        DK_MIXED = 2'b10,
        DK_FAST2 = 2'b11
    } decay_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gates_t;

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hbp_seq.sv
module hbp_seq
    import hbp_pkg::*;
#(
    parameter int DEAD_CYCLES  = 50,
    parameter int OFF_CYCLES   = 40,
    parameter int BLANK_CYCLES = 8,
    parameter int CW           = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dir_i,
    input  logic          code_nz_i,
    input  logic          trip_i,
    input  decay_e        decay_i,
    output phase_e        phase_o,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output decay_e        decay_o
);
    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic          dir;
        decay_e        dk;
    } seq_t;

    localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYCLES - 1);
    localparam logic [CW-1:0] OFF_LAST  = CW'(OFF_CYCLES - 1);
    localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CYCLES);

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!code_nz_i) begin
            s_d.phase = PH_DEAD;
            s_d.cnt   = '0;
            s_d.dir   = dir_i;
        end else if (dir_i != s_q.dir) begin
            s_d.phase = PH_DEAD;
            s_d.cnt   = '0;
            s_d.dir   = dir_i;
        end else begin
            case (s_q.phase)
                PH_DEAD: begin
                    if (s_q.cnt == DEAD_LAST) begin
                        s_d.phase = PH_ON;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_ON: begin
                    if (trip_i && (s_q.cnt >= BLANK_END)) begin
                        s_d.phase = PH_OFF;
                        s_d.cnt   = '0;
                        s_d.dk    = decay_i;
                    end else if (s_q.cnt < BLANK_END) begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                PH_OFF: begin
                    if (s_q.cnt == OFF_LAST) begin
                        s_d.phase = PH_ON;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    s_d.phase = PH_DEAD;
                    s_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_DEAD;
            s_q.cnt   <= '0;
            s_q.dir   <= 1'b0;
            s_q.dk    <= DK_SLOW;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;
    assign cnt_o   = s_q.cnt;
    assign dir_o   = s_q.dir;
    assign decay_o = s_q.dk;
endmodule

// File: rtl/hbp_gate.sv
module hbp_gate
    import hbp_pkg::*;
#(
    parameter int MIX_CYCLES = 10,
    parameter int CW         = 6
) (
    input  phase_e        phase_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          dir_i,
    input  decay_e        decay_i,
    input  logic          code_nz_i,
    output gates_t        gates_o
);
    localparam logic [CW-1:0] MIX_END = CW'(MIX_CYCLES);

    logic hs_on, ls_on, ls_recirc;

    always_comb begin
        case (decay_i)
            DK_SLOW:  ls_recirc = 1'b1;
            DK_MIXED: ls_recirc = (cnt_i >= MIX_END);
            default:  ls_recirc = 1'b0;
        endcase
        hs_on = code_nz_i && (phase_i == PH_ON);
        ls_on = code_nz_i && ((phase_i == PH_ON) ||
                              ((phase_i == PH_OFF) && ls_recirc));
        gates_o = '0;
        if (!dir_i) begin
            gates_o.hs_a = hs_on;
            gates_o.ls_b = ls_on;
        end else begin
            gates_o.hs_b = hs_on;
            gates_o.ls_a = ls_on;
        end
    end
endmodule

// File: rtl/hbridge_pwm_ctrl.sv
module hbridge_pwm_ctrl
    import hbp_pkg::*;
#(
    parameter int LEVEL_W      = 3,
    parameter int DEAD_CYCLES  = 50,
    parameter int OFF_CYCLES   = 40,
    parameter int BLANK_CYCLES = 8,
    parameter int MIX_FAST_NUM = 1,
    parameter int MIX_FAST_DEN = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_i,
    input  logic [LEVEL_W-1:0] level_i,
    input  logic [1:0]         decay_i,
    input  logic               trip_i,
    output logic               hs_a_o,
    output logic               ls_a_o,
    output logic               hs_b_o,
    output logic               ls_b_o,
    output logic [LEVEL_W-1:0] dac_code_o
);
    localparam int MAX_AB  = (DEAD_CYCLES > OFF_CYCLES) ? DEAD_CYCLES : OFF_CYCLES;
    localparam int CNT_MAX = (MAX_AB > BLANK_CYCLES + 1) ? MAX_AB : BLANK_CYCLES + 1;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam int MIX_CYC = OFF_CYCLES * MIX_FAST_NUM / MIX_FAST_DEN;

    logic [LEVEL_W-1:0] code_d, code_q;
    logic               trip_s;
    phase_e             phase;
    logic [CW-1:0]      cnt;
    logic               dir_act;
    decay_e             dk_act;
    gates_t             gates;

    always_comb code_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    hbp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (trip_i),
        .q_o   (trip_s)
    );

    hbp_seq #(
        .DEAD_CYCLES  (DEAD_CYCLES),
        .OFF_CYCLES   (OFF_CYCLES),
        .BLANK_CYCLES (BLANK_CYCLES),
        .CW           (CW)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_i     (dir_i),
        .code_nz_i (code_q != '0),
        .trip_i    (trip_s),
        .decay_i   (decay_e'(decay_i)),
        .phase_o   (phase),
        .cnt_o     (cnt),
        .dir_o     (dir_act),
        .decay_o   (dk_act)
    );

    hbp_gate #(.MIX_CYCLES(MIX_CYC), .CW(CW)) u_gate (
        .phase_i   (phase),
        .cnt_i     (cnt),
        .dir_i     (dir_act),
        .decay_i   (dk_act),
        .code_nz_i (code_q != '0),
        .gates_o   (gates)
    );

    assign hs_a_o     = gates.hs_a;
    assign ls_a_o     = gates.ls_a;
    assign hs_b_o     = gates.hs_b;
    assign ls_b_o     = gates.ls_b;
    assign dac_code_o = code_q;
endmodule

// File: rtl/hbp_chk.sv
module hbp_chk #(
    parameter int LEVEL_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dir_i,
    input logic               hs_a_o,
    input logic               ls_a_o,
    input logic               hs_b_o,
    input logic               ls_b_o,
    input logic [LEVEL_W-1:0] dac_code_o
);
    assert_leg_a_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_a_o && ls_a_o));

    assert_leg_b_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_b_o && ls_b_o));

    assert_one_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_a_o || ls_b_o) |-> !(hs_b_o || ls_a_o));

    assert_no_direct_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_a_o || ls_b_o) |=> !(hs_b_o || ls_a_o));

    assert_no_direct_swap_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_b_o || ls_a_o) |=> !(hs_a_o || ls_b_o));

    assert_dir_change_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_i != $past(dir_i)) |=> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

    assert_zero_code_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code_o == '0) |-> !(hs_a_o || ls_a_o || hs_b_o || ls_b_o));

    assert_blank_a_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_a_o) && !dir_i && (dac_code_o != '0)) |=> hs_a_o);

    assert_blank_b_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hs_b_o) && dir_i && (dac_code_o != '0)) |=> hs_b_o);
endmodule

bind hbridge_pwm_ctrl hbp_chk #(.LEVEL_W(LEVEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dir_i      (dir_i),
    .hs_a_o     (hs_a_o),
    .ls_a_o     (ls_a_o),
    .hs_b_o     (hs_b_o),
    .ls_b_o     (ls_b_o),
    .dac_code_o (dac_code_o)
);

// File: tb/sim_hbridge_pwm_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_pwm_ctrl;
    localparam int DEAD  = 50;
    localparam int OFFT  = 40;
    localparam int BLANK = 8;
    localparam int MIXC  = OFFT * 1 / 4;
    localparam int NV    = 10;

    // {dir, level[2:0], decay[1:0], on{hsA,lsA,hsB,lsB}, early_off, late_off}
    localparam logic [17:0] VEC [NV] = '{
        18'b0_100_00_1001_0001_0001,
        18'b0_100_01_1001_0000_0000,
        18'b0_100_10_1001_0000_0001,
        18'b0_001_11_1001_0000_0000,
        18'b1_111_00_0110_0100_0100,
        18'b1_111_01_0110_0000_0000,
        18'b1_010_10_0110_0000_0100,
        18'b1_000_00_0000_0000_0000,
        18'b0_000_10_0000_0000_0000,
        18'b0_110_00_1001_0001_0001
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir = 1'b0;
    logic [2:0] level = 3'd3;
    logic [1:0] decay = 2'b00;
    logic       trip = 1'b0;
    logic       hs_a, ls_a, hs_b, ls_b;
    logic [2:0] dac;
    logic [3:0] g;
    int         nchk = 0;
    int         nfail = 0;
    int         overlap = 0;
    int         cnt;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    hbridge_pwm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .dir_i(dir), .level_i(level),
        .decay_i(decay), .trip_i(trip),
        .hs_a_o(hs_a), .ls_a_o(ls_a), .hs_b_o(hs_b), .ls_b_o(ls_b),
        .dac_code_o(dac)
    );

    assign g = {hs_a, ls_a, hs_b, ls_b};

    // R11 monitor: same-leg overlap on any cycle
    always @(negedge clk)
        if (rst_n && ((hs_a && ls_a) || (hs_b && ls_b))) overlap++;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_while_gates(input logic [3:0] pat, output int n);
        n = 1;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (g == pat) n++;
            else break;
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        tick(3);
        chk("R12 gates in reset", int'(g), 0);
        chk("R12 dac in reset", int'(dac), 0);
        rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (g == 4'b0000) cnt++;
            else break;
        end
        chk("R12 off cycles after reset", cnt, DEAD);
        chk("R2 first conduction pair dir0", int'(g), 4'b1001);

        // table of vectors: R1 R2 R3 R4 R5 R6 R7 R9
        for (int v = 0; v < NV; v++) begin
            dir   = VEC[v][17];
            level = VEC[v][16:14];
            decay = VEC[v][13:12];
            tick(DEAD + BLANK + 4);
            chk($sformatf("R1/R2 on pattern v%0d", v), int'(g), int'(VEC[v][11:8]));
            chk($sformatf("R9 dac code v%0d", v), int'(dac), int'(VEC[v][16:14]));
            trip = 1'b1;
            tick(4);
            chk($sformatf("R3/R4/R5/R6 early off v%0d", v), int'(g), int'(VEC[v][7:4]));
            trip = 1'b0;
            tick(20);
            chk($sformatf("R4/R5/R6 late off v%0d", v), int'(g), int'(VEC[v][3:0]));
            tick(25);
            chk($sformatf("R7 re-enable v%0d", v), int'(g), int'(VEC[v][11:8]));
        end

        // R8: dead time on reversal
        tick(10);
        dir = 1'b1;
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (g == 4'b0000) cnt++;
            else break;
        end
        chk("R8 dead cycles", cnt, DEAD);
        chk("R8 new pair", int'(g), 4'b0110);

        // R7: exact slow-decay off-time
        decay = 2'b00;
        tick(10);
        trip = 1'b1;
        for (int i = 0; i < 50 && hs_b; i++) @(negedge clk);
        trip = 1'b0;
        chk("R4 slow off pattern", int'(g), 4'b0100);
        count_while_gates(4'b0100, cnt);
        chk("R7 off-time length", cnt, OFFT);
        chk("R7 conduction after off-time", int'(g), 4'b0110);

        // R6: mixed-decay fast portion length
        decay = 2'b10;
        tick(10);
        trip = 1'b1;
        for (int i = 0; i < 50 && hs_b; i++) @(negedge clk);
        trip = 1'b0;
        count_while_gates(4'b0000, cnt);
        chk("R6 mixed fast cycles", cnt, MIXC);
        chk("R6 mixed slow part", int'(g), 4'b0100);

        // R10: trip during off-time ignored, then blanking window
        trip = 1'b1;
        count_while_gates(4'b0100, cnt);
        chk("R10 off-time with trip held", cnt, OFFT - MIXC);
        count_while_gates(4'b0110, cnt);
        chk("R10 on length with trip held", cnt, BLANK + 1);
        trip = 1'b0;
        decay = 2'b00;
        tick(60);
        chk("R3 stays on without trip", int'(g), 4'b0110);

        // R9: zero code mid-conduction and recovery
        level = 3'd0;
        tick(1);
        chk("R9 zero code forces off", int'(g), 0);
        chk("R9 dac zero", int'(dac), 0);
        trip = 1'b1;
        tick(5);
        trip = 1'b0;
        chk("R9 off with trip toggled", int'(g), 0);
        tick(5);
        level = 3'd5;
        cnt = 0;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            if (i == 0) chk("R9 dac follows level", int'(dac), 5);
            if (g == 4'b0000) cnt++;
            else break;
        end
        chk("R9 off cycles leaving zero code", cnt, DEAD);
        chk("R1 pair for dir1", int'(g), 4'b0110);

        chk("R11 same-leg overlap cycles", overlap, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule